// File: doc/BRIEF.md
# Conflict-Tolerant Dual-Port Bit-Plane Memory

This block is a two-port memory made only from single-port storage. Each word is spread across storage columns. There is one column per data bit and one more column for a parity bit. Each column is cut into banks, and each bank holds one bit for several words. In every column, each port is steered to exactly one bank. The bank number comes from the upper address bits and the lower address bits, combined with the column number by arithmetic in a small finite field. Because of this mapping, two different words can share a bank in one column at most.

Port A can read or write, and it always wins a bank that both ports select. Port B can only read. When port B loses a bank, its bit from that column is dropped and the column raises an erasure flag. The read path rebuilds the lost bit from the odd parity that was stored with the word. Both ports therefore return full, correct words one clock after they present an address, and neither port ever stalls.

Top module: `cfmem_dual`

## Requirements
- R1: While reset is held, all stored words become data 0 with a valid parity bit, and `a_rdata`, `b_rdata`, `b_erase` and `b_wr_err` read 0. After reset, every address reads back 0 on both ports.
- R2: The clock edge that samples an address updates `a_rdata` and `b_rdata` to the word stored at that address. A word written through port A reads back unchanged on both ports from the next cycle onward.
- R3: If port A reads an address in the same cycle that it writes that address, `a_rdata` returns the word held before the write.
- R4: Address bits [N0+N1-1:N1] form the bank base x0, and bits [N1-1:0] form the slope x1. Column y uses bank x0 ^ (x1 * y), computed in GF(2^N0) with polynomial x^2+x+1 at the default size. `b_erase[y]` goes high in the same cycle as the data when both ports map to the same bank in column y with different addresses. Column index DW is the parity column.
- R5: For any two distinct addresses, at most one bit of `b_erase` is set.
- R6: Port B returns the correct stored word even when one of its columns is erased. The bit is rebuilt from the odd parity that every port A write stores, and this holds while port A writes another address in the same cycle.
- R7: When both ports present the same address, `b_erase` stays 0 and `b_rdata` equals `a_rdata`.
- R8: A port B write request changes no stored word. One cycle later, `b_wr_err` is high for exactly one cycle for each requesting cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| a_addr | input | N0+N1 | Port A address |
| a_we | input | 1 | Port A write strobe |
| a_wdata | input | DW | Port A write data |
| a_rdata | output | DW | Port A registered read data |
| b_addr | input | N0+N1 | Port B address |
| b_we | input | 1 | Port B write request (refused) |
| b_rdata | output | DW | Port B registered, repaired read data |
| b_erase | output | DW+1 | Per-column erasure flags for port B |
| b_wr_err | output | 1 | One-cycle pulse for a refused port B write |

## Verification
The main stimulus reads every ordered pair of addresses after the memory is filled with words of differing parity. This covers three cases: identical addresses (no erasure), pairs with equal slope (no shared bank), and pairs that collide in exactly one column, including the parity column. In each case the erasure mask is predicted from the bench's own field product, which separates a wrong bank mapping from a wrong repair. A second pattern has port A write while port B reads, so the two paths interact. Separate sequences cover a read at the address being written and refused port B writes. In the refused-write case, the targeted word is read back afterwards to confirm it is unchanged.

// File: rtl/cfmem_dual.sv
module cfmem_dual #(
  parameter int N0 = 2,
  parameter int N1 = 2,
  parameter int DW = 3,
  parameter logic [N0-1:0] POLY = 2'b11
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N0+N1-1:0]     a_addr,
  input  logic                 a_we,
  input  logic [DW-1:0]        a_wdata,
  output logic [DW-1:0]        a_rdata,
  input  logic [N0+N1-1:0]     b_addr,
  input  logic                 b_we,
  output logic [DW-1:0]        b_rdata,
  output logic [DW:0]          b_erase,
  output logic                 b_wr_err
);
  localparam int AW    = N0 + N1;
  localparam int COLS  = DW + 1;
  localparam int DEPTH = 1 << AW;

  function automatic logic [N0-1:0] gf_mul(input logic [N0-1:0] a, input logic [N0-1:0] b);
    logic [N0-1:0] acc, sh;
    acc = '0;
    sh  = a;
    for (int i = 0; i < N0; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = sh[N0-1] ? ((sh << 1) ^ POLY) : (sh << 1);
    end
    return acc;
  endfunction

  logic [N0-1:0] baseA, baseB, slopeA, slopeB;
  logic [N1-1:0] offA, offB;
  assign baseA  = a_addr[AW-1:N1];
  assign baseB  = b_addr[AW-1:N1];
  assign offA   = a_addr[N1-1:0];
  assign offB   = b_addr[N1-1:0];
  assign slopeA = N0'(offA);
  assign slopeB = N0'(offB);

  logic [COLS-1:0] wword;
  assign wword = {~^a_wdata, a_wdata};

  logic [COLS-1:0] rdA, rdB, clash;
  logic [COLS-1:0] rawA_q, rawB_q;

  for (genvar c = 0; c < COLS; c++) begin : g_col
    localparam logic [N0-1:0] YC = N0'(c);
    logic [N0-1:0]    binA, binB;
    logic [AW-1:0]    idxA, idxB;
    logic [DEPTH-1:0] col_q;

    assign binA = baseA ^ gf_mul(slopeA, YC);
    assign binB = baseB ^ gf_mul(slopeB, YC);
    assign idxA = {binA, offA};
    assign idxB = {binB, offB};
    assign clash[c] = (binA == binB) && (offA != offB);
    assign rdA[c]   = col_q[idxA];
    assign rdB[c]   = clash[c] ? 1'b0 : col_q[idxB];

    always_ff @(posedge clk) begin
      if (!rst_n) col_q <= (c == DW) ? '1 : '0;
      else if (a_we) col_q[idxA] <= wword[c];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rawA_q   <= '0;
      rawB_q   <= '0;
      b_erase  <= '0;
      b_wr_err <= 1'b0;
    end else begin
      rawA_q   <= rdA;
      rawB_q   <= rdB;
      b_erase  <= clash;
      b_wr_err <= b_we;
    end
  end

  logic [COLS-1:0] fixB;
  assign fixB    = rawB_q ^ (b_erase & {COLS{~(^rawB_q)}});
  assign a_rdata = rawA_q[DW-1:0];
  assign b_rdata = fixB[DW-1:0];

  // R5
  unit_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(b_erase));

  // R7
  same_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (a_addr == b_addr) |=> (b_erase == '0 && b_rdata == a_rdata));

  // R8
  b_write_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    b_we |=> b_wr_err);

  // R8
  b_write_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    b_wr_err |-> $past(b_we));

  // R2
  write_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(a_we) && !a_we && $past(a_addr) == a_addr) |=> (a_rdata == $past(a_wdata, 2)));
endmodule

// File: tb/cfmem_dual_tb.sv
module cfmem_dual_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] a_addr = '0, b_addr = '0;
  logic       a_we = 1'b0, b_we = 1'b0;
  logic [2:0] a_wdata = '0;
  logic [2:0] a_rdata, b_rdata;
  logic [3:0] b_erase;
  logic       b_wr_err;

  int checks = 0;
  int failures = 0;
  logic [2:0] model [16];

  always #2 clk = ~clk;

  cfmem_dual dut_i (
    .clk(clk), .rst_n(rst_n),
    .a_addr(a_addr), .a_we(a_we), .a_wdata(a_wdata), .a_rdata(a_rdata),
    .b_addr(b_addr), .b_we(b_we), .b_rdata(b_rdata),
    .b_erase(b_erase), .b_wr_err(b_wr_err)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] fmul(input logic [1:0] a, input logic [1:0] b);
    logic [1:0] r;
    r[0] = (a[0] & b[0]) ^ (a[1] & b[1]);
    r[1] = (a[1] & b[0]) ^ (a[0] & b[1]) ^ (a[1] & b[1]);
    return r;
  endfunction

  function automatic logic [3:0] exp_erase(input logic [3:0] x, input logic [3:0] z);
    logic [3:0] m;
    m = '0;
    for (int y = 0; y < 4; y++)
      if (x != z && (x[3:2] ^ fmul(x[1:0], 2'(y))) == (z[3:2] ^ fmul(z[1:0], 2'(y))))
        m[y] = 1'b1;
    return m;
  endfunction

  task automatic cyc(input logic [3:0] aa, input logic aw, input logic [2:0] ad,
                     input logic [3:0] ba, input logic bw);
    @(negedge clk);
    a_addr = aa; a_we = aw; a_wdata = ad; b_addr = ba; b_we = bw;
    @(negedge clk);
    a_we = 1'b0; b_we = 1'b0;
  endtask

  task automatic t_reset;
    check("R1 a_rdata", a_rdata, 0);
    check("R1 b_rdata", b_rdata, 0);
    check("R1 b_erase", b_erase, 0);
    check("R1 b_wr_err", b_wr_err, 0);
    for (int i = 0; i < 16; i++) begin
      cyc(4'(i), 1'b0, 3'd0, 4'(15 - i), 1'b0);
      check("R1 a word", a_rdata, 0);
      check("R1 b word", b_rdata, 0);
      model[i] = 3'd0;
    end
  endtask

  task automatic t_fill;
    for (int i = 0; i < 16; i++) begin
      cyc(4'(i), 1'b1, 3'((i * 5 + 3) % 8), 4'(i), 1'b0);
      model[i] = 3'((i * 5 + 3) % 8);
    end
    for (int i = 0; i < 16; i++) begin
      cyc(4'(i), 1'b0, 3'd0, 4'(i), 1'b0);
      check("R2 a readback", a_rdata, model[i]);
      check("R2 b readback", b_rdata, model[i]);
    end
  endtask

  task automatic t_read_first;
    cyc(4'd9, 1'b1, 3'd6, 4'd2, 1'b0);
    check("R3 old word on write cycle", a_rdata, model[9]);
    model[9] = 3'd6;
    cyc(4'd9, 1'b1, 3'd1, 4'd9, 1'b0);
    check("R3 old word second write", a_rdata, 3'd6);
    model[9] = 3'd1;
    cyc(4'd9, 1'b0, 3'd0, 4'd9, 1'b0);
    check("R2 new word visible", a_rdata, 3'd1);
  endtask

  task automatic t_pairs;
    for (int i = 0; i < 16; i++)
      for (int j = 0; j < 16; j++) begin
        cyc(4'(i), 1'b0, 3'd0, 4'(j), 1'b0);
        check("R4 erase mask", b_erase, exp_erase(4'(i), 4'(j)));
        check("R6 b repaired", b_rdata, model[j]);
        check("R2 a data", a_rdata, model[i]);
        if (i == j) check("R7 shared word", b_rdata, a_rdata);
        check("R5 single erasure", $countones(b_erase) <= 1, 1);
      end
  endtask

  task automatic t_mixed;
    for (int k = 0; k < 32; k++) begin
      logic [3:0] wa, rb;
      logic [2:0] wd;
      wa = 4'((k * 7) % 16);
      rb = 4'((k * 3 + 1) % 16);
      if (rb == wa) rb = rb + 4'd1;
      wd = 3'((k * 3 + 5) % 8);
      cyc(wa, 1'b1, wd, rb, 1'b0);
      check("R6 b during write", b_rdata, model[rb]);
      check("R4 erase during write", b_erase, exp_erase(wa, rb));
      model[wa] = wd;
    end
    for (int i = 0; i < 16; i++) begin
      cyc(4'(i), 1'b0, 3'd0, 4'((i + 5) % 16), 1'b0);
      check("R6 a after mixed", a_rdata, model[i]);
      check("R6 b after mixed", b_rdata, model[(i + 5) % 16]);
    end
  endtask

  task automatic t_bwrite;
    logic [2:0] keep;
    keep = model[4];
    @(negedge clk);
    a_addr = 4'd0; b_addr = 4'd4; b_we = 1'b1;
    @(negedge clk);
    check("R8 error pulse", b_wr_err, 1);
    b_we = 1'b0;
    @(negedge clk);
    check("R8 pulse ends", b_wr_err, 0);
    cyc(4'd4, 1'b0, 3'd0, 4'd4, 1'b0);
    check("R8 word untouched a", a_rdata, keep);
    check("R8 word untouched b", b_rdata, keep);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset_pre: begin
      check("R1 erase in reset", b_erase, 0);
    end
    rst_n = 1'b1;
    t_reset();
    t_fill();
    t_read_first();
    t_pairs();
    t_mixed();
    t_bwrite();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule